// File: doc/BRIEF.md
# Asynchronous Serial Transmitter with Fractional Stop Length

This block is the sending half of one asynchronous serial channel. A host writes a character into a one-entry holding register. When the shifter is idle and the clear-to-send input is high, the character moves into the shifter and goes out on the line. The frame is a low start bit, then 5 to 8 data bits with the least significant bit first, then an optional parity bit, then a high stop period. The stop period is measured in sixteenths of a bit, so it can be any length from one bit to two bits in steps of one sixteenth.

All bit timing comes from a single-cycle enable, `tick16`, that pulses sixteen times per bit. The block derives no baud rate of its own. The frame format is captured when a character enters the shifter, so the host may change it while a character is still being sent. On request, the block holds the line low as a break once the character in progress has finished.

Two status outputs tell the host whether the holding register can take another character and whether the channel has fully drained.

Top module: `uart_tx_frac`

## Requirements
- R1: After reset, `txd` is 1, `hold_empty` is 1 and `tx_empty` is 1.
- R2: A `wr_en` pulse while `hold_empty` is 1 stores `wr_data` and drives `hold_empty` low on the next clock. A write while `hold_empty` is 0 is ignored, and the stored character is kept.
- R3: A stored character moves to the shifter only when the shifter is idle, `cts` is 1 and `break_req` is 0. While `cts` is 0, the line stays at 1 and the character stays held.
- R4: A frame starts with 16 ticks of 0. Then come the data bits, least significant bit first, 16 ticks each. The number of data bits is `len_code`+5, so code 0 gives 5 bits and code 3 gives 8 bits.
- R5: `parity_mode` selects the bit that follows the data. 0 means no parity bit. 1 means even parity, where the bit equals the XOR of the data bits sent. 2 means odd parity, the inverse of that. 3 forces a 0. 4 forces a 1. A parity bit lasts 16 ticks.
- R6: The stop period holds the line at 1 for `stop_ticks` ticks. Values below 16 are treated as 16, and values above 32 are treated as 32.
- R7: `len_code`, `parity_mode` and `stop_ticks` are sampled when the character enters the shifter. Changing them during the frame does not change that frame.
- R8: When `break_req` is 1, the line goes to 0 at the end of the current character, or at once if the shifter is idle. It stays at 0 while `break_req` stays 1, and it returns to 1 on the clock after `break_req` falls. A character held during the break is sent only after the release.
- R9: `tx_empty` is 1 only when the holding register is empty and no character is in the shifter. `hold_empty` returns to 1 on the same clock edge on which the start bit begins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tick16 | input | 1 | Enable pulse, sixteen per bit time |
| wr_en | input | 1 | Write strobe for the holding register |
| wr_data | input | 8 | Character to send |
| len_code | input | 2 | Data length code; length is code+5 |
| parity_mode | input | 3 | 0 none, 1 even, 2 odd, 3 force 0, 4 force 1 |
| stop_ticks | input | 6 | Stop length in ticks, clamped to 16..32 |
| cts | input | 1 | Clear to send; gates the start of a character |
| break_req | input | 1 | Request to hold the line low |
| txd | output | 1 | Serial line, idle high |
| hold_empty | output | 1 | Holding register can take a character |
| tx_empty | output | 1 | Holding register and shifter are both empty |

## Verification
`hold_empty` falls one clock after a write. The character enters the shifter on the next clock, and on that same edge `txd` falls and `hold_empty` rises. After that, every bit boundary falls on the edge that consumes the 16th tick of the bit, or the `stop_ticks`-th tick of the stop period. The bench therefore samples `txd` at the falling clock edge in each cycle where `tick16` is high, and compares tick number i against the bit computed arithmetically as bit i/16 of the expected frame. Idle, empty and break levels are checked at the first falling edge after the edge that consumes the last stop tick, or after the edge that follows a change of `break_req`.

// File: rtl/uart_txf_pkg.sv
package uart_txf_pkg;

    localparam int TICKS_PER_BIT = 16;
    localparam int STOP_MIN      = 16;
    localparam int STOP_MAX      = 32;
    localparam int TCNT_W        = 6;
    localparam int CHAR_W        = 8;
    localparam int LEN_BASE      = 5;

    typedef enum logic [2:0] {
        PAR_NONE     = 3'd0,
        PAR_EVEN     = 3'd1,
        PAR_ODD      = 3'd2,
        PAR_FORCE_LO = 3'd3,
        PAR_FORCE_HI = 3'd4
    } par_mode_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_PAR,
        ST_STOP,
        ST_BREAK
    } tx_state_e;

    typedef struct packed {
        logic              par_en;
        logic              par_val;
        logic [3:0]        nbits;
        logic [TCNT_W-1:0] stop_lim;
    } frame_fmt_t;

    function automatic logic [CHAR_W-1:0] len_mask(input logic [1:0] code);
        return {CHAR_W{1'b1}} >> (2'd3 - code);
    endfunction

    function automatic logic calc_parity(input logic [CHAR_W-1:0] d,
                                         input logic [1:0] code,
                                         input par_mode_e mode);
        logic ones;
        ones = ^(d & len_mask(code));
        case (mode)
            PAR_EVEN:     return ones;
            PAR_ODD:      return ~ones;
            PAR_FORCE_HI: return 1'b1;
            default:      return 1'b0;
        endcase
    endfunction

    function automatic logic [TCNT_W-1:0] clamp_stop(input logic [TCNT_W-1:0] v);
        if (v < TCNT_W'(STOP_MIN)) return TCNT_W'(STOP_MIN);
        if (v > TCNT_W'(STOP_MAX)) return TCNT_W'(STOP_MAX);
        return v;
    endfunction

endpackage

// File: rtl/utx_hold_reg.sv
module utx_hold_reg #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              take,
    output logic              full,
    output logic [DATA_W-1:0] data
);
    always_ff @(posedge clk) begin
        if (rst) begin
            full <= 1'b0;
            data <= '0;
        end else if (take) begin
            full <= 1'b0;
        end else if (wr_en && !full) begin
            full <= 1'b1;
            data <= wr_data;
        end
    end
endmodule

// File: rtl/utx_bit_timer.sv
module utx_bit_timer #(
    parameter int CNT_W = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic             clear,
    input  logic [CNT_W-1:0] limit,
    output logic             done
);
    logic [CNT_W-1:0] cnt;

    assign done = tick && !clear && (cnt == limit - CNT_W'(1));

    always_ff @(posedge clk) begin
        if (rst || clear) cnt <= '0;
        else if (tick)    cnt <= done ? '0 : cnt + CNT_W'(1);
    end
endmodule

// File: rtl/utx_frame_fsm.sv
module utx_frame_fsm
    import uart_txf_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              hold_full,
    input  logic [CHAR_W-1:0] hold_data,
    input  logic [1:0]        len_code,
    input  logic [2:0]        parity_mode,
    input  logic [TCNT_W-1:0] stop_ticks,
    input  logic              cts,
    input  logic              break_req,
    input  logic              bit_done,
    output logic              take,
    output logic              timer_clear,
    output logic [TCNT_W-1:0] timer_limit,
    output logic              busy,
    output logic              txd
);
    tx_state_e         state;
    logic [CHAR_W-1:0] shreg;
    logic [3:0]        bits_left;
    frame_fmt_t        fmt;
    par_mode_e         pmode;

    assign pmode       = par_mode_e'(parity_mode);
    assign take        = (state == ST_IDLE) && hold_full && cts && !break_req;
    assign timer_clear = (state == ST_IDLE) || (state == ST_BREAK);
    assign timer_limit = (state == ST_STOP) ? fmt.stop_lim : TCNT_W'(TICKS_PER_BIT);
    assign busy        = !timer_clear;

    always_comb begin
        case (state)
            ST_START, ST_BREAK: txd = 1'b0;
            ST_DATA:            txd = shreg[0];
            ST_PAR:             txd = fmt.par_val;
            default:            txd = 1'b1;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_IDLE;
            shreg     <= '0;
            bits_left <= '0;
            fmt       <= '0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (break_req) begin
                        state <= ST_BREAK;
                    end else if (take) begin
                        state        <= ST_START;
                        shreg        <= hold_data;
                        bits_left    <= 4'(len_code) + 4'(LEN_BASE);
                        fmt.nbits    <= 4'(len_code) + 4'(LEN_BASE);
                        fmt.par_en   <= (pmode != PAR_NONE);
                        fmt.par_val  <= calc_parity(hold_data, len_code, pmode);
                        fmt.stop_lim <= clamp_stop(stop_ticks);
                    end
                end
                ST_START: if (bit_done) state <= ST_DATA;
                ST_DATA: begin
                    if (bit_done) begin
                        shreg     <= shreg >> 1;
                        bits_left <= bits_left - 4'd1;
                        if (bits_left == 4'd1)
                            state <= fmt.par_en ? ST_PAR : ST_STOP;
                    end
                end
                ST_PAR:  if (bit_done) state <= ST_STOP;
                ST_STOP: if (bit_done) state <= break_req ? ST_BREAK : ST_IDLE;
                ST_BREAK: if (!break_req) state <= ST_IDLE;
                default: state <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/uart_tx_frac.sv
module uart_tx_frac
    import uart_txf_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        tick16,
    input  logic        wr_en,
    input  logic [7:0]  wr_data,
    input  logic [1:0]  len_code,
    input  logic [2:0]  parity_mode,
    input  logic [5:0]  stop_ticks,
    input  logic        cts,
    input  logic        break_req,
    output logic        txd,
    output logic        hold_empty,
    output logic        tx_empty
);
    logic              hold_full;
    logic [CHAR_W-1:0] hold_data;
    logic              take;
    logic              timer_clear;
    logic [TCNT_W-1:0] timer_limit;
    logic              bit_done;
    logic              busy;

    utx_hold_reg #(.DATA_W(CHAR_W)) i_hold (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .take    (take),
        .full    (hold_full),
        .data    (hold_data)
    );

    utx_bit_timer #(.CNT_W(TCNT_W)) i_timer (
        .clk   (clk),
        .rst   (rst),
        .tick  (tick16),
        .clear (timer_clear),
        .limit (timer_limit),
        .done  (bit_done)
    );

    utx_frame_fsm i_fsm (
        .clk         (clk),
        .rst         (rst),
        .hold_full   (hold_full),
        .hold_data   (hold_data),
        .len_code    (len_code),
        .parity_mode (parity_mode),
        .stop_ticks  (stop_ticks),
        .cts         (cts),
        .break_req   (break_req),
        .bit_done    (bit_done),
        .take        (take),
        .timer_clear (timer_clear),
        .timer_limit (timer_limit),
        .busy        (busy),
        .txd         (txd)
    );

    assign hold_empty = !hold_full;
    assign tx_empty   = !hold_full && !busy;
endmodule

// File: rtl/uart_tx_frac_chk.sv
module uart_tx_frac_chk (
    input logic clk,
    input logic rst,
    input logic wr_en,
    input logic cts,
    input logic break_req,
    input logic txd,
    input logic hold_empty,
    input logic tx_empty
);
    assert_empty_needs_hold_R9: assert property (@(posedge clk) disable iff (rst)
        tx_empty |-> hold_empty);

    assert_fill_needs_write_R2: assert property (@(posedge clk) disable iff (rst)
        $fell(hold_empty) |-> $past(wr_en));

    assert_start_needs_cts_R3: assert property (@(posedge clk) disable iff (rst)
        $rose(hold_empty) |-> $past(cts) && !$past(break_req));

    assert_idle_marks_R8: assert property (@(posedge clk) disable iff (rst)
        (tx_empty && !break_req && !$past(break_req)) |-> txd);
endmodule

bind uart_tx_frac uart_tx_frac_chk i_chk (
    .clk        (clk),
    .rst        (rst),
    .wr_en      (wr_en),
    .cts        (cts),
    .break_req  (break_req),
    .txd        (txd),
    .hold_empty (hold_empty),
    .tx_empty   (tx_empty)
);

// File: tb/test_uart_tx_frac.sv
`timescale 1ns/1ps
module test_uart_tx_frac;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick16 = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic [1:0] len_code = '0;
    logic [2:0] parity_mode = '0;
    logic [5:0] stop_ticks = 6'd16;
    logic       cts = 1'b1;
    logic       break_req = 1'b0;
    logic       txd, hold_empty, tx_empty;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 0;

    always #2 clk = ~clk;

    uart_tx_frac i_uart_tx_frac (
        .clk(clk), .rst(rst), .tick16(tick16), .wr_en(wr_en), .wr_data(wr_data),
        .len_code(len_code), .parity_mode(parity_mode), .stop_ticks(stop_ticks),
        .cts(cts), .break_req(break_req), .txd(txd), .hold_empty(hold_empty),
        .tx_empty(tx_empty)
    );

    initial begin
        int ph = 0;
        forever begin
            @(posedge clk);
            ph = (ph + 1) % 4;
            tick16 <= (ph == 0);
        end
    end

    task automatic chk(input bit ok, input string what, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
        end
    endtask

    function automatic int stop_len(input int s);
        if (s < 16) return 16;
        if (s > 32) return 32;
        return s;
    endfunction

    function automatic logic exp_bit(input int i, input logic [7:0] d, input int n, input int pm);
        int b;
        logic ones;
        b = i / 16;
        ones = 1'b0;
        for (int k = 0; k < n; k++) ones ^= d[k];
        if (b == 0) return 1'b0;
        if (b <= n) return d[b-1];
        if (b == n + 1 && pm != 0) begin
            case (pm)
                1: return ones;
                2: return ~ones;
                3: return 1'b0;
                default: return 1'b1;
            endcase
        end
        return 1'b1;
    endfunction

    task automatic wait_low(output bit ok);
        ok = 0;
        for (int c = 0; c < 3000; c++) begin
            if (txd == 1'b0) begin ok = 1; break; end
            @(negedge clk);
        end
    endtask

    // mode: 0 plain, 1 change format during frame, 2 raise break during frame
    task automatic frame(input logic [7:0] d, input int lc, input int pm, input int st,
                         input bit do_write, input int mode, input string tag);
        int  n, total, idx, bad, first_bad_i;
        logic first_bad_v;
        bit  ok;
        n = lc + 5;
        total = (1 + n + (pm != 0 ? 1 : 0)) * 16 + stop_len(st);
        if (do_write) begin
            len_code = 2'(lc); parity_mode = 3'(pm); stop_ticks = 6'(st);
            wr_data = d; wr_en = 1'b1;
            @(negedge clk);
            wr_en = 1'b0;
        end
        wait_low(ok);
        chk(ok, {tag, " start bit seen"}, ok, 1);
        if (!ok) return;
        chk(hold_empty == 1'b1 && tx_empty == 1'b0, "R9 status at start bit",
            {hold_empty, tx_empty}, 2);
        if (mode == 1) begin
            len_code = 2'(3 - lc); parity_mode = 3'((pm + 2) % 5); stop_ticks = 6'd29;
        end
        if (mode == 2) break_req = 1'b1;
        idx = 0; bad = 0; first_bad_i = -1; first_bad_v = 1'b0;
        while (idx < total) begin
            if (tick16) begin
                if (txd !== exp_bit(idx, d, n, pm)) begin
                    if (bad == 0) begin first_bad_i = idx; first_bad_v = txd; end
                    bad++;
                end
                idx++;
            end
            if (idx < total) @(negedge clk);
        end
        chk(bad == 0, $sformatf("%s frame d=%02h len=%0d par=%0d stop=%0d tick%0d",
            tag, d, n, pm, st, first_bad_i), first_bad_v, exp_bit(first_bad_i, d, n, pm));
        @(negedge clk);
        if (mode == 2) begin
            chk(txd == 1'b0, "R8 break after character", txd, 0);
        end else begin
            chk(txd == 1'b1 && tx_empty == 1'b1, {tag, " R6 R9 idle after stop"},
                {txd, tx_empty}, 3);
        end
    endtask

    initial begin
        bit ok;
        int k;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(txd == 1'b1, "R1 reset txd", txd, 1);
        chk(hold_empty == 1'b1, "R1 reset hold_empty", hold_empty, 1);
        chk(tx_empty == 1'b1, "R1 reset tx_empty", tx_empty, 1);

        // R4 R5 R6 sweep over length, parity and stop
        k = 0;
        for (int lc = 0; lc < 4; lc++)
            for (int pm = 0; pm < 5; pm++)
                for (int si = 0; si < 4; si++) begin
                    int st;
                    st = (si == 0) ? 16 : (si == 1) ? 17 : (si == 2) ? 24 : 32;
                    frame(8'(8'hA5 ^ (k * 37)), lc, pm, st, 1'b1, 0, "R4 R5 R6 sweep");
                    k++;
                end

        // R6 clamping
        frame(8'h3C, 3, 0, 40, 1'b1, 0, "R6 clamp high");
        frame(8'hC3, 1, 1, 3, 1'b1, 0, "R6 clamp low");

        // R7 format captured at transfer
        frame(8'h96, 3, 1, 16, 1'b1, 1, "R7 mid change");
        frame(8'h0F, 0, 4, 20, 1'b1, 1, "R7 mid change");

        // R3 and R2: cts low holds character, second write ignored
        cts = 1'b0;
        len_code = 2'd3; parity_mode = 3'd0; stop_ticks = 6'd16;
        wr_data = 8'h5A; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
        chk(hold_empty == 1'b0, "R2 hold fills one clock after write", hold_empty, 0);
        wr_data = 8'hFF; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
        begin
            int lows;
            lows = 0;
            for (int c = 0; c < 300; c++) begin
                if (txd == 1'b0) lows++;
                @(negedge clk);
            end
            chk(lows == 0, "R3 line stays high without cts", lows, 0);
        end
        chk(hold_empty == 1'b0 && tx_empty == 1'b0, "R3 character stays held",
            {hold_empty, tx_empty}, 0);
        cts = 1'b1;
        frame(8'h5A, 3, 0, 16, 1'b0, 0, "R2 R3 first value sent");
        begin
            int lows;
            lows = 0;
            for (int c = 0; c < 400; c++) begin
                if (txd == 1'b0) lows++;
                @(negedge clk);
            end
            chk(lows == 0, "R2 ignored write not sent", lows, 0);
        end

        // R8 break after current character, pending char waits
        frame(8'hE7, 2, 2, 24, 1'b1, 2, "R8 frame before break");
        chk(tx_empty == 1'b1, "R9 empty during break", tx_empty, 1);
        wr_data = 8'h81; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
        begin
            int highs;
            highs = 0;
            for (int c = 0; c < 200; c++) begin
                if (txd == 1'b1) highs++;
                @(negedge clk);
            end
            chk(highs == 0, "R8 line held low during break", highs, 0);
        end
        chk(hold_empty == 1'b0 && tx_empty == 1'b0, "R8 character held during break",
            {hold_empty, tx_empty}, 0);
        break_req = 1'b0;
        @(negedge clk);
        chk(txd == 1'b1, "R8 line marks after release", txd, 1);
        frame(8'h81, 2, 2, 24, 1'b0, 0, "R8 held char after break");

        // R8 break from idle
        break_req = 1'b1;
        @(negedge clk);
        chk(txd == 1'b0, "R8 break from idle", txd, 0);
        break_req = 1'b0;
        @(negedge clk);
        chk(txd == 1'b1 && tx_empty == 1'b1, "R8 release from idle", {txd, tx_empty}, 3);

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule